// File: doc/BRIEF.md
# Two-Channel Serial Interrupt Arbiter

This block keeps the interrupt bookkeeping for a pair of serial channels, A and B, that share one interrupt request line. For each channel it remembers whether a received character is waiting, whether a transmit-buffer-empty event is waiting, which of the two is currently being serviced, and whether a break condition was seen. From that state it drives the shared request, a byte of pending flags and an interrupt vector byte that names the source being serviced.

The surrounding serial logic reports events as one-cycle strobes per channel. These are a character arrival, the transmit buffer going empty, a read of the data register and a break being detected. The host's command decoder passes on a 3-bit command code with a strobe. The interrupt-enable fields come in as static level inputs. A receive in service holds off transmit service. Retiring receive service promotes a waiting transmit into service. The vector byte takes one of two encodings, selected by a single mode input. All outputs are registered and reflect the events of the previous clock.

Top module: `sio_irq_arbiter`

## Requirements
- R1: While `rst` is high, and on the first clock after it, `irq`, `pend_status` and `vector` all read 0x00, and every internal flag is clear.
- R2: `irq` is high when, for at least one channel, one of these holds: `tx_ie` is set and transmit is pending; the channel's receive mode is 2'b01 or 2'b10 and receive is pending; `brk_ie` is set and the channel's break flag is set. Receive modes 2'b00 and 2'b11 never raise the request.
- R3: `rx_char` sets the channel's receive-pending and receive-in-service flags and loads that channel's receive code into `vector`.
- R4: `tx_empty` sets the channel's transmit-pending flag. It sets transmit-in-service and loads the transmit code only when the channel has no receive in service; otherwise the vector is left as it was.
- R5: With `hi_status` low the vector codes are: no interrupt 0x06, receive A 0x0C, receive B 0x04, transmit A 0x08, transmit B 0x00.
- R6: With `hi_status` high the codes are: no interrupt 0x60, receive A 0x30, receive B 0x20, transmit A 0x10, transmit B 0x00.
- R7: `pend_status` bit 5 is receive-pending A, bit 4 is transmit-pending A gated by `tx_ie[0]`, bit 2 is receive-pending B, bit 1 is transmit-pending B gated by `tx_ie[1]`, and bits 7, 6, 3 and 0 are zero.
- R8: `data_rd` clears the channel's receive-pending and receive-in-service flags and loads the no-interrupt code. If transmit is still pending, the transmit event is then applied again as in R4.
- R9: Command code 3'b111 does one of two things. If receive is in service, it clears that flag and re-applies a pending transmit as in R4. Otherwise it clears transmit-in-service and leaves the vector alone.
- R10: Command code 3'b101 clears transmit-pending and transmit-in-service and loads the no-interrupt code. If receive is still pending, the receive event is then re-applied as in R3. Every other command code has no effect.
- R11: `brk_det` sets the channel's break flag, which stays set until reset.
- R12: Events in one cycle are applied in this order: channel A before channel B, and within a channel data read, then command, then `rx_char`, then `tx_empty`, then break. The last vector load wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_char | input | 2 | Character received strobe, bit 0 channel A, bit 1 channel B |
| tx_empty | input | 2 | Transmit buffer emptied strobe per channel |
| data_rd | input | 2 | Data register read strobe per channel |
| brk_det | input | 2 | Break detected strobe per channel |
| cmd_stb | input | 2 | Command strobe per channel |
| cmd_code_a | input | 3 | Command code for channel A |
| cmd_code_b | input | 3 | Command code for channel B |
| tx_ie | input | 2 | Transmit interrupt enable per channel |
| rx_mode_a | input | 2 | Receive interrupt mode of channel A |
| rx_mode_b | input | 2 | Receive interrupt mode of channel B |
| brk_ie | input | 2 | Break interrupt enable per channel |
| hi_status | input | 1 | Selects the high-bit vector encoding |
| irq | output | 1 | Shared interrupt request |
| pend_status | output | 8 | Pending flags byte |
| vector | output | 8 | Interrupt vector byte |

## Verification
The collisions that matter most are a character arrival and a transmit-empty on the same channel in one cycle, and receive events on both channels in one cycle. In the first, receive service must block the transmit from taking the vector. In the second, channel B's code must overwrite channel A's. Directed cycles place these pairs on the same edge, together with a data read or command landing next to a new event. A bench model that applies the events in the order of R12 predicts the vector, the pending byte and the request. Random cycles then mix all strobes and command codes to reach the rarer overlaps.

// File: rtl/sio_irq_pkg.sv
package sio_irq_pkg;

  localparam int NCH   = 2;
  localparam int VEC_W = 8;
  localparam int CMD_W = 3;

  localparam logic [CMD_W-1:0] CMD_CLR_TXP = 3'b101;
  localparam logic [CMD_W-1:0] CMD_CLR_IUS = 3'b111;

  typedef struct packed {
    logic rxp;   // receive pending
    logic txp;   // transmit pending
    logic rxs;   // receive in service
    logic txs;   // transmit in service
    logic brk;   // break seen
  } chan_flags_t;

  localparam chan_flags_t FLAGS_CLR = '0;

  function automatic logic [VEC_W-1:0] none_code(input logic hi);
    return hi ? 8'h60 : 8'h06;
  endfunction

  function automatic logic [VEC_W-1:0] rx_code(input int ch, input logic hi);
    if (ch == 0) return hi ? 8'h30 : 8'h0C;
    return hi ? 8'h20 : 8'h04;
  endfunction

  function automatic logic [VEC_W-1:0] tx_code(input int ch, input logic hi);
    if (ch == 0) return hi ? 8'h10 : 8'h08;
    return 8'h00;
  endfunction

endpackage

// File: rtl/sio_irq_stage.sv
module sio_irq_stage
  import sio_irq_pkg::*;
#(
  parameter int CH = 0
) (
  input  chan_flags_t       flags_i,
  input  logic [VEC_W-1:0]  vec_i,
  input  logic              data_rd,
  input  logic              cmd_stb,
  input  logic [CMD_W-1:0]  cmd_code,
  input  logic              rx_char,
  input  logic              tx_empty,
  input  logic              brk_det,
  input  logic              hi_status,
  output chan_flags_t       flags_o,
  output logic [VEC_W-1:0]  vec_o
);

  localparam logic [VEC_W-1:0] RXC_LO = rx_code(CH, 1'b0);
  localparam logic [VEC_W-1:0] RXC_HI = rx_code(CH, 1'b1);
  localparam logic [VEC_W-1:0] TXC_LO = tx_code(CH, 1'b0);
  localparam logic [VEC_W-1:0] TXC_HI = tx_code(CH, 1'b1);

  logic [VEC_W-1:0] rxc, txc, nonec;
  chan_flags_t      f;
  logic [VEC_W-1:0] v;

  assign rxc   = hi_status ? RXC_HI : RXC_LO;
  assign txc   = hi_status ? TXC_HI : TXC_LO;
  assign nonec = none_code(hi_status);

  always_comb begin
    f = flags_i;
    v = vec_i;
    // data register read retires receive, then re-raises a waiting transmit
    if (data_rd) begin
      f.rxp = 1'b0;
      f.rxs = 1'b0;
      v     = nonec;
      if (f.txp) begin
        f.txs = 1'b1;
        v     = txc;
      end
    end
    // host command
    if (cmd_stb) begin
      if (cmd_code == CMD_CLR_TXP) begin
        f.txp = 1'b0;
        f.txs = 1'b0;
        v     = nonec;
        if (f.rxp) begin
          f.rxs = 1'b1;
          v     = rxc;
        end
      end else if (cmd_code == CMD_CLR_IUS) begin
        if (f.rxs) begin
          f.rxs = 1'b0;
          if (f.txp) begin
            f.txs = 1'b1;
            v     = txc;
          end
        end else begin
          f.txs = 1'b0;
        end
      end
    end
    if (rx_char) begin
      f.rxp = 1'b1;
      f.rxs = 1'b1;
      v     = rxc;
    end
    if (tx_empty) begin
      f.txp = 1'b1;
      if (!f.rxs) begin
        f.txs = 1'b1;
        v     = txc;
      end
    end
    if (brk_det) f.brk = 1'b1;
  end

  assign flags_o = f;
  assign vec_o   = v;

endmodule

// File: rtl/sio_irq_encode.sv
module sio_irq_encode
  import sio_irq_pkg::*;
(
  input  chan_flags_t      fa,
  input  chan_flags_t      fb,
  input  logic [NCH-1:0]   tx_ie,
  input  logic [1:0]       rx_mode_a,
  input  logic [1:0]       rx_mode_b,
  input  logic [NCH-1:0]   brk_ie,
  output logic             irq,
  output logic [VEC_W-1:0] status
);

  logic rx_on_a, rx_on_b, cond_a, cond_b;

  assign rx_on_a = (rx_mode_a == 2'b01) || (rx_mode_a == 2'b10);
  assign rx_on_b = (rx_mode_b == 2'b01) || (rx_mode_b == 2'b10);

  assign cond_a = (tx_ie[0] & fa.txp) | (rx_on_a & fa.rxp) | (brk_ie[0] & fa.brk);
  assign cond_b = (tx_ie[1] & fb.txp) | (rx_on_b & fb.rxp) | (brk_ie[1] & fb.brk);

  assign irq = cond_a | cond_b;

  always_comb begin
    status    = '0;
    status[5] = fa.rxp;
    status[4] = fa.txp & tx_ie[0];
    status[2] = fb.rxp;
    status[1] = fb.txp & tx_ie[1];
  end

endmodule

// File: rtl/sio_irq_arbiter.sv
module sio_irq_arbiter
  import sio_irq_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic [1:0]       rx_char,
  input  logic [1:0]       tx_empty,
  input  logic [1:0]       data_rd,
  input  logic [1:0]       brk_det,
  input  logic [1:0]       cmd_stb,
  input  logic [2:0]       cmd_code_a,
  input  logic [2:0]       cmd_code_b,
  input  logic [1:0]       tx_ie,
  input  logic [1:0]       rx_mode_a,
  input  logic [1:0]       rx_mode_b,
  input  logic [1:0]       brk_ie,
  input  logic             hi_status,
  output logic             irq,
  output logic [7:0]       pend_status,
  output logic [7:0]       vector
);

  chan_flags_t      flags_q [NCH];
  chan_flags_t      flags_d [NCH];
  logic [VEC_W-1:0] vec_chain [NCH+1];
  logic [CMD_W-1:0] cmd_code [NCH];
  logic [VEC_W-1:0] vec_q;
  logic             irq_d;
  logic [VEC_W-1:0] status_d;
  logic             irq_q;
  logic [VEC_W-1:0] status_q;

  assign cmd_code[0]  = cmd_code_a;
  assign cmd_code[1]  = cmd_code_b;
  assign vec_chain[0] = vec_q;

  // channel A is applied first, channel B may overwrite its vector load
  for (genvar c = 0; c < NCH; c++) begin : g_ch
    sio_irq_stage #(.CH(c)) u_stage (
      .flags_i   (flags_q[c]),
      .vec_i     (vec_chain[c]),
      .data_rd   (data_rd[c]),
      .cmd_stb   (cmd_stb[c]),
      .cmd_code  (cmd_code[c]),
      .rx_char   (rx_char[c]),
      .tx_empty  (tx_empty[c]),
      .brk_det   (brk_det[c]),
      .hi_status (hi_status),
      .flags_o   (flags_d[c]),
      .vec_o     (vec_chain[c+1])
    );

    always_ff @(posedge clk) begin
      if (rst) flags_q[c] <= FLAGS_CLR;
      else     flags_q[c] <= flags_d[c];
    end
  end

  sio_irq_encode u_enc (
    .fa        (flags_d[0]),
    .fb        (flags_d[1]),
    .tx_ie     (tx_ie),
    .rx_mode_a (rx_mode_a),
    .rx_mode_b (rx_mode_b),
    .brk_ie    (brk_ie),
    .irq       (irq_d),
    .status    (status_d)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      vec_q    <= '0;
      irq_q    <= 1'b0;
      status_q <= '0;
    end else begin
      vec_q    <= vec_chain[NCH];
      irq_q    <= irq_d;
      status_q <= status_d;
    end
  end

  assign irq         = irq_q;
  assign pend_status = status_q;
  assign vector      = vec_q;

endmodule

// File: rtl/sio_irq_checker.sv
module sio_irq_checker (
  input logic       clk,
  input logic       rst,
  input logic [1:0] rx_char,
  input logic [1:0] tx_empty,
  input logic [1:0] data_rd,
  input logic [1:0] brk_det,
  input logic [1:0] cmd_stb,
  input logic [2:0] cmd_code_a,
  input logic [2:0] cmd_code_b,
  input logic [1:0] tx_ie,
  input logic [1:0] brk_ie,
  input logic       hi_status,
  input logic       irq,
  input logic [7:0] pend_status,
  input logic [7:0] vector
);

  a_r1_reset_clears: assert property (@(posedge clk)
    rst |=> (!irq && pend_status == 8'h00 && vector == 8'h00));

  // R3 with R12: A receive with no B activity lands A's receive code
  a_r3_rx_vector_a: assert property (@(posedge clk) disable iff (rst)
    (rx_char[0] && rx_char[1] == 1'b0 && tx_empty[1] == 1'b0 &&
     data_rd[1] == 1'b0 && cmd_stb[1] == 1'b0)
    |=> (pend_status[5] && vector == ($past(hi_status) ? 8'h30 : 8'h0C)));

  a_r4_tx_pending_b: assert property (@(posedge clk) disable iff (rst)
    (tx_empty[1] && tx_ie[1]) |=> pend_status[1]);

  a_r8_read_clears_rx: assert property (@(posedge clk) disable iff (rst)
    (data_rd[0] && !rx_char[0]) |=> !pend_status[5]);

  a_r10_clear_tx_b: assert property (@(posedge clk) disable iff (rst)
    (cmd_stb[1] && cmd_code_b == 3'b101 && !tx_empty[1]) |=> !pend_status[1]);

  a_r11_break_irq: assert property (@(posedge clk) disable iff (rst)
    (brk_det[0] && brk_ie[0]) |=> irq);

endmodule

bind sio_irq_arbiter sio_irq_checker u_chk (
  .clk         (clk),
  .rst         (rst),
  .rx_char     (rx_char),
  .tx_empty    (tx_empty),
  .data_rd     (data_rd),
  .brk_det     (brk_det),
  .cmd_stb     (cmd_stb),
  .cmd_code_a  (cmd_code_a),
  .cmd_code_b  (cmd_code_b),
  .tx_ie       (tx_ie),
  .brk_ie      (brk_ie),
  .hi_status   (hi_status),
  .irq         (irq),
  .pend_status (pend_status),
  .vector      (vector)
);

// File: tb/sio_irq_arbiter_tb.sv
module sio_irq_arbiter_tb;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [1:0] rx_char = '0, tx_empty = '0, data_rd = '0, brk_det = '0, cmd_stb = '0;
  logic [2:0] cmd_code_a = '0, cmd_code_b = '0;
  logic [1:0] tx_ie = '0, rx_mode_a = '0, rx_mode_b = '0, brk_ie = '0;
  logic       hi_status = 1'b0;
  logic       irq;
  logic [7:0] pend_status, vector;

  int compared = 0;
  int mismatched = 0;
  bit done = 0;
  string tag = "R1";

  // reference model state
  bit       m_rxp [2], m_txp [2], m_rxs [2], m_txs [2], m_brk [2];
  bit [7:0] m_vec;
  bit       e_irq;
  bit [7:0] e_stat, e_vec;

  always #10 clk = ~clk;

  sio_irq_arbiter u_dut (
    .clk(clk), .rst(rst), .rx_char(rx_char), .tx_empty(tx_empty),
    .data_rd(data_rd), .brk_det(brk_det), .cmd_stb(cmd_stb),
    .cmd_code_a(cmd_code_a), .cmd_code_b(cmd_code_b), .tx_ie(tx_ie),
    .rx_mode_a(rx_mode_a), .rx_mode_b(rx_mode_b), .brk_ie(brk_ie),
    .hi_status(hi_status), .irq(irq), .pend_status(pend_status), .vector(vector)
  );

  function automatic bit [7:0] f_none(bit hi);
    return hi ? 8'h60 : 8'h06;
  endfunction
  function automatic bit [7:0] f_rx(int c, bit hi);
    if (c == 0) return hi ? 8'h30 : 8'h0C;
    return hi ? 8'h20 : 8'h04;
  endfunction
  function automatic bit [7:0] f_tx(int c, bit hi);
    if (c == 0) return hi ? 8'h10 : 8'h08;
    return 8'h00;
  endfunction

  task automatic model_reset();
    for (int c = 0; c < 2; c++) begin
      m_rxp[c] = 0; m_txp[c] = 0; m_rxs[c] = 0; m_txs[c] = 0; m_brk[c] = 0;
    end
    m_vec = 8'h00; e_irq = 0; e_stat = 8'h00; e_vec = 8'h00;
  endtask

  task automatic raise_tx(int c);
    m_txp[c] = 1;
    if (!m_rxs[c]) begin m_txs[c] = 1; m_vec = f_tx(c, hi_status); end
  endtask

  task automatic raise_rx(int c);
    m_rxp[c] = 1; m_rxs[c] = 1; m_vec = f_rx(c, hi_status);
  endtask

  // R12 order: A then B; read, command, rx, tx, break
  task automatic model_step();
    bit [2:0] code;
    bit       on;
    for (int c = 0; c < 2; c++) begin
      code = (c == 0) ? cmd_code_a : cmd_code_b;
      if (data_rd[c]) begin
        m_rxp[c] = 0; m_rxs[c] = 0; m_vec = f_none(hi_status);
        if (m_txp[c]) raise_tx(c);
      end
      if (cmd_stb[c]) begin
        if (code == 3'b101) begin
          m_txp[c] = 0; m_txs[c] = 0; m_vec = f_none(hi_status);
          if (m_rxp[c]) raise_rx(c);
        end else if (code == 3'b111) begin
          if (m_rxs[c]) begin
            m_rxs[c] = 0;
            if (m_txp[c]) raise_tx(c);
          end else m_txs[c] = 0;
        end
      end
      if (rx_char[c]) raise_rx(c);
      if (tx_empty[c]) raise_tx(c);
      if (brk_det[c]) m_brk[c] = 1;
    end
    e_irq = 0;
    for (int c = 0; c < 2; c++) begin
      on = (c == 0) ? (rx_mode_a == 2'b01 || rx_mode_a == 2'b10)
                    : (rx_mode_b == 2'b01 || rx_mode_b == 2'b10);
      if ((tx_ie[c] && m_txp[c]) || (on && m_rxp[c]) || (brk_ie[c] && m_brk[c]))
        e_irq = 1;
    end
    e_stat = {2'b00, m_rxp[0], m_txp[0] & tx_ie[0], 1'b0, m_rxp[1], m_txp[1] & tx_ie[1], 1'b0};
    e_vec  = m_vec;
  endtask

  task automatic check8(string what, bit [7:0] got, bit [7:0] exp);
    compared++;
    if (got !== exp) begin
      mismatched++;
      $display("FAIL %s %s: got %02h expected %02h at %0t", tag, what, got, exp, $time);
    end
  endtask

  task automatic check_all();
    check8("irq", {7'd0, irq}, {7'd0, e_irq});
    check8("pend_status", pend_status, e_stat);
    check8("vector", vector, e_vec);
  endtask

  task automatic clear_ev();
    rx_char = '0; tx_empty = '0; data_rd = '0; brk_det = '0; cmd_stb = '0;
  endtask

  // inputs were set at a falling edge; predict and check at the next one
  task automatic tick();
    model_step();
    @(negedge clk);
    check_all();
    clear_ev();
  endtask

  task automatic cmd(int c, bit [2:0] code);
    cmd_stb[c] = 1'b1;
    if (c == 0) cmd_code_a = code; else cmd_code_b = code;
  endtask

  initial begin
    int seed;
    seed = $urandom(32'h5EED_0042);
    model_reset();
    repeat (3) @(negedge clk);
    tag = "R1";
    check_all();
    rst = 1'b0;
    @(negedge clk);
    check_all();

    // R3 R4 R5 R8 R9 R10: channel A in low-status mode
    tx_ie = 2'b11; rx_mode_a = 2'b01; rx_mode_b = 2'b10; hi_status = 1'b0;
    tag = "R3"; rx_char[0] = 1'b1; tick();
    tag = "R4"; tx_empty[0] = 1'b1; tick();
    tag = "R8"; data_rd[0] = 1'b1; tick();
    tag = "R9"; cmd(0, 3'b111); tick();
    tag = "R10"; cmd(0, 3'b101); tick();
    tag = "R5"; tx_empty[0] = 1'b1; tick();
    tag = "R5"; rx_char[1] = 1'b1; tick();
    tag = "R9"; cmd(1, 3'b111); tick();

    // R6 R9 R10: channel B in high-status mode
    hi_status = 1'b1;
    tag = "R6"; data_rd[1] = 1'b1; tick();
    tag = "R6"; rx_char[1] = 1'b1; tick();
    tag = "R4"; tx_empty[1] = 1'b1; tick();
    tag = "R9"; cmd(1, 3'b111); tick();
    tag = "R10"; cmd(1, 3'b101); tick();
    tag = "R10"; cmd(1, 3'b011); tx_empty[0] = 1'b0; tick();
    tag = "R8"; data_rd[1] = 1'b1; tick();
    tag = "R6"; rx_char[0] = 1'b1; tick();

    // R7 R2: gating and receive modes
    tag = "R7"; tx_empty = 2'b11; tx_ie = 2'b00; tick();
    tag = "R2"; rx_mode_a = 2'b11; tick();
    tag = "R2"; rx_mode_a = 2'b00; data_rd[1] = 1'b1; tick();
    tag = "R7"; tx_ie = 2'b10; tick();

    // R11: break stays until reset
    tag = "R11"; cmd(0, 3'b101); cmd(1, 3'b101); data_rd = 2'b11; tick();
    tag = "R11"; brk_det[1] = 1'b1; brk_ie = 2'b00; tx_ie = 2'b00; tick();
    tag = "R11"; brk_ie = 2'b10; tick();
    tag = "R11"; data_rd[1] = 1'b1; tick();

    // R12: same-cycle collisions
    hi_status = 1'b0;
    tag = "R12"; rx_char = 2'b11; tick();
    tag = "R12"; data_rd = 2'b11; tick();
    tag = "R12"; rx_char[0] = 1'b1; tx_empty[0] = 1'b1; tick();
    tag = "R12"; data_rd[0] = 1'b1; rx_char[0] = 1'b1; tick();
    tag = "R12"; cmd(0, 3'b111); tx_empty[1] = 1'b1; tick();

    // random mix
    tag = "R2 R7 R12 random";
    for (int i = 0; i < 3000; i++) begin
      rx_char    = (($urandom % 4) == 0) ? 2'($urandom) : 2'b00;
      tx_empty   = (($urandom % 4) == 0) ? 2'($urandom) : 2'b00;
      data_rd    = (($urandom % 4) == 0) ? 2'($urandom) : 2'b00;
      brk_det    = (($urandom % 32) == 0) ? 2'($urandom) : 2'b00;
      cmd_stb    = (($urandom % 4) == 0) ? 2'($urandom) : 2'b00;
      cmd_code_a = 3'($urandom);
      cmd_code_b = 3'($urandom);
      if (($urandom % 16) == 0) begin
        tx_ie = 2'($urandom); rx_mode_a = 2'($urandom); rx_mode_b = 2'($urandom);
        brk_ie = 2'($urandom); hi_status = 1'($urandom);
      end
      tick();
    end

    // R1 again: reset mid-run
    tag = "R1";
    rst = 1'b1;
    rx_char = 2'b11; tx_empty = 2'b11;
    @(negedge clk);
    model_reset();
    check_all();
    rst = 1'b0; clear_ev();
    @(negedge clk);
    check_all();

    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      compared++; mismatched++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

endmodule